// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 28-bit physical address. It reads a two-level page table that sits in memory. A caller presents one translate request, made of the virtual address and the physical base of the first-level table. The walker then makes up to two word reads on a simple request/response memory port. It ends the walk with a one-cycle `done` pulse that carries the physical address, or with a one-cycle `fault` pulse.

Pages are 8 KB, so the 13 low address bits pass through unchanged as the page offset. The 19-bit virtual page number is split unevenly:

- The upper 8 bits select one of 256 four-byte entries in a 1 KB first-level table.
- The lower 11 bits select one of 2048 entries in an 8 KB second-level table.

A table entry is valid when its bit 0 is set. Bits 27:13 of an entry hold a 15-bit page number. For a first-level entry, that number names the page that holds the second-level table. For a second-level entry, it names the target page.

A walk that finds an invalid first-level entry stops with a fault and makes no second read. Requests are accepted only while the walker is idle.

Top module: `pgwalk_top`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_req_valid`, `done` and `fault` are 0.
- R2: The first read goes to address `l1_base + 4*va[31:24]`. Index 4 of a table at 0x0010000 is therefore read at 0x0010010.
- R3: After a valid first-level entry E1, the second read goes to address `{E1[27:13], 13'b0} + 4*va[23:13]`.
- R4: After a valid second-level entry E2, `done` pulses with `paddr = {E2[27:13], va[12:0]}`. Entry bits 31:28 and 12:1 have no effect.
- R5: A first-level entry with bit 0 clear ends the walk with a `fault` pulse and no `done`. Exactly one memory read is made.
- R6: A second-level entry with bit 0 clear ends the walk with a `fault` pulse after exactly two memory reads.
- R7: `done` and `fault` are never high together, and each is high for exactly one cycle per walk.
- R8: `req_ready` is 0 from the cycle after a request is accepted until the walk finishes. A request presented during a walk is ignored: it causes no extra read and does not change the result.
- R9: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request and its address stay unchanged. The walk completes correctly under any number of stall cycles and any response latency.
- R10: Two virtual addresses read the same first-level entry exactly when their bits 31:24 match. For example, 0x12345678 and 0x123FD000 read the same entry, while 0x00046678 reads a different one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translate request present |
| req_vaddr | input | 32 | Virtual address to translate |
| req_l1_base | input | 28 | Physical base of the first-level table |
| req_ready | output | 1 | Walker idle; a request is taken on this cycle |
| mem_req_valid | output | 1 | Word read request |
| mem_req_addr | output | 28 | Byte address of the entry to read |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Entry read from memory |
| done | output | 1 | One-cycle pulse: translation succeeded |
| fault | output | 1 | One-cycle pulse: translation failed |
| paddr | output | 28 | Translated physical address, valid with `done` |

## Verification
The hardest case to reach from the ports is a new request arriving while a walk is in flight. The walker must ignore that request, but it would expose a flaw only if it disturbed the walk or caused an extra read. To reach this case, the bench memory model stalls `mem_req_ready` and delays responses, which stretches the walk. The bench then raises `req_valid` with a different address in the middle of the walk. It checks three things: `req_ready` stayed low, the read count stayed at two, and the result matches the first address. The first-level-fault path is told apart from the second-level one by counting the reads the memory model serves.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  typedef enum logic [2:0] {
    WS_IDLE  = 3'd0,
    WS_RD_L1 = 3'd1,
    WS_WT_L1 = 3'd2,
    WS_RD_L2 = 3'd3,
    WS_WT_L2 = 3'd4,
    WS_FIN   = 3'd5
  } walk_state_e;

  localparam int unsigned DEF_VA_W       = 32;
  localparam int unsigned DEF_PA_W       = 28;
  localparam int unsigned DEF_OFS_W      = 13;
  localparam int unsigned DEF_L1_IDX_W   = 8;
  localparam int unsigned DEF_PTE_W      = 32;
  localparam int unsigned DEF_PTE_BYTES_LOG2 = 2;

endpackage

// File: rtl/pgwalk_split.sv
module pgwalk_split #(
  parameter int unsigned VA_W     = 32,
  parameter int unsigned OFS_W    = 13,
  parameter int unsigned L1_IDX_W = 8,
  localparam int unsigned L2_IDX_W = VA_W - OFS_W - L1_IDX_W
) (
  input  logic [VA_W-1:0]     vaddr,
  output logic [L1_IDX_W-1:0] idx_top,
  output logic [L2_IDX_W-1:0] idx_mid,
  output logic [OFS_W-1:0]    offset
);
  assign idx_top = vaddr[VA_W-1 -: L1_IDX_W];
  assign idx_mid = vaddr[OFS_W +: L2_IDX_W];
  assign offset  = vaddr[OFS_W-1:0];
endmodule

// File: rtl/pgwalk_entry_addr.sv
module pgwalk_entry_addr #(
  parameter int unsigned PA_W      = 28,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned BYTES_LOG2 = 2,
  localparam int unsigned PAD_W    = PA_W - IDX_W - BYTES_LOG2
) (
  input  logic [PA_W-1:0]  table_base,
  input  logic [IDX_W-1:0] index,
  output logic [PA_W-1:0]  entry_addr
);
  logic [PA_W-1:0] scaled;
  assign scaled     = {{PAD_W{1'b0}}, index, {BYTES_LOG2{1'b0}}};
  assign entry_addr = table_base + scaled;
endmodule

// File: rtl/pgwalk_pte_decode.sv
module pgwalk_pte_decode #(
  parameter int unsigned PTE_W = 32,
  parameter int unsigned PA_W  = 28,
  parameter int unsigned OFS_W = 13,
  localparam int unsigned PPN_W = PA_W - OFS_W
) (
  input  logic [PTE_W-1:0] pte,
  output logic             present,
  output logic [PPN_W-1:0] ppn,
  output logic [PA_W-1:0]  page_base
);
  logic unused_pte_bits;
  assign present   = pte[0];
  assign ppn       = pte[OFS_W +: PPN_W];
  assign page_base = {ppn, {OFS_W{1'b0}}};
  assign unused_pte_bits = ^{pte[PTE_W-1:PA_W], pte[OFS_W-1:1]};
endmodule

// File: rtl/pgwalk_seq.sv
module pgwalk_seq
  import pgwalk_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        mem_req_ready,
  input  logic        mem_rsp_valid,
  input  logic        pte_present,
  output walk_state_e state,
  output logic        take_req,
  output logic        load_l2,
  output logic        load_res,
  output logic        load_flt
);
  walk_state_e nxt;

  assign take_req = (state == WS_IDLE) && req_valid;
  assign load_l2  = (state == WS_WT_L1) && mem_rsp_valid && pte_present;
  assign load_res = (state == WS_WT_L2) && mem_rsp_valid && pte_present;
  assign load_flt = ((state == WS_WT_L1) || (state == WS_WT_L2)) &&
                    mem_rsp_valid && !pte_present;

  always_comb begin
    nxt = state;
    case (state)
      WS_IDLE:  if (req_valid)     nxt = WS_RD_L1;
      WS_RD_L1: if (mem_req_ready) nxt = WS_WT_L1;
      WS_WT_L1: if (mem_rsp_valid) nxt = pte_present ? WS_RD_L2 : WS_FIN;
      WS_RD_L2: if (mem_req_ready) nxt = WS_WT_L2;
      WS_WT_L2: if (mem_rsp_valid) nxt = WS_FIN;
      WS_FIN:                      nxt = WS_IDLE;
      default:                     nxt = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= WS_IDLE;
    else     state <= nxt;
  end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int unsigned VA_W       = DEF_VA_W,
  parameter int unsigned PA_W       = DEF_PA_W,
  parameter int unsigned OFS_W      = DEF_OFS_W,
  parameter int unsigned L1_IDX_W   = DEF_L1_IDX_W,
  parameter int unsigned PTE_W      = DEF_PTE_W,
  parameter int unsigned BYTES_LOG2 = DEF_PTE_BYTES_LOG2,
  localparam int unsigned L2_IDX_W  = VA_W - OFS_W - L1_IDX_W,
  localparam int unsigned PPN_W     = PA_W - OFS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [PA_W-1:0]  req_l1_base,
  output logic             req_ready,
  output logic             mem_req_valid,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_req_ready,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             done,
  output logic             fault,
  output logic [PA_W-1:0]  paddr
);
  walk_state_e state;
  logic take_req, load_l2, load_res, load_flt;

  logic [L1_IDX_W-1:0] in_idx_top;
  logic [L2_IDX_W-1:0] in_idx_mid;
  logic [OFS_W-1:0]    in_ofs;
  logic [L2_IDX_W-1:0] idx_mid_q;
  logic [OFS_W-1:0]    ofs_q;

  logic             pte_present;
  logic [PPN_W-1:0] pte_ppn;
  logic [PA_W-1:0]  pte_page;
  logic [PA_W-1:0]  l1_entry, l2_entry;

  logic [PA_W-1:0]  addr_q;
  logic [PA_W-1:0]  paddr_q;
  logic             flt_q;

  pgwalk_split #(.VA_W(VA_W), .OFS_W(OFS_W), .L1_IDX_W(L1_IDX_W)) u_split (
    .vaddr   (req_vaddr),
    .idx_top (in_idx_top),
    .idx_mid (in_idx_mid),
    .offset  (in_ofs)
  );

  pgwalk_pte_decode #(.PTE_W(PTE_W), .PA_W(PA_W), .OFS_W(OFS_W)) u_dec (
    .pte       (mem_rsp_data),
    .present   (pte_present),
    .ppn       (pte_ppn),
    .page_base (pte_page)
  );

  pgwalk_entry_addr #(.PA_W(PA_W), .IDX_W(L1_IDX_W), .BYTES_LOG2(BYTES_LOG2)) u_ea1 (
    .table_base (req_l1_base),
    .index      (in_idx_top),
    .entry_addr (l1_entry)
  );

  pgwalk_entry_addr #(.PA_W(PA_W), .IDX_W(L2_IDX_W), .BYTES_LOG2(BYTES_LOG2)) u_ea2 (
    .table_base (pte_page),
    .index      (idx_mid_q),
    .entry_addr (l2_entry)
  );

  pgwalk_seq u_seq (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .pte_present   (pte_present),
    .state         (state),
    .take_req      (take_req),
    .load_l2       (load_l2),
    .load_res      (load_res),
    .load_flt      (load_flt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_mid_q <= '0;
      ofs_q     <= '0;
      addr_q    <= '0;
      paddr_q   <= '0;
      flt_q     <= 1'b0;
    end else begin
      if (take_req) begin
        idx_mid_q <= in_idx_mid;
        ofs_q     <= in_ofs;
        addr_q    <= l1_entry;
      end
      if (load_l2) addr_q <= l2_entry;
      if (load_res) begin
        paddr_q <= {pte_ppn, ofs_q};
        flt_q   <= 1'b0;
      end
      if (load_flt) begin
        paddr_q <= '0;
        flt_q   <= 1'b1;
      end
    end
  end

  assign req_ready     = (state == WS_IDLE);
  assign mem_req_valid = (state == WS_RD_L1) || (state == WS_RD_L2);
  assign mem_req_addr  = addr_q;
  assign done          = (state == WS_FIN) && !flt_q;
  assign fault         = (state == WS_FIN) && flt_q;
  assign paddr         = paddr_q;
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned PA_W  = 28,
  parameter int unsigned OFS_W = 13
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic [VA_W-1:0] req_vaddr,
  input logic            req_ready,
  input logic            mem_req_valid,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            mem_req_ready,
  input logic            done,
  input logic            fault,
  input logic [PA_W-1:0] paddr
);
  logic [OFS_W-1:0] seen_ofs;

  always_ff @(posedge clk) begin
    if (rst)                         seen_ofs <= '0;
    else if (req_valid && req_ready) seen_ofs <= req_vaddr[OFS_W-1:0];
  end

  assert_not_both_R7: assert property (@(posedge clk) disable iff (rst)
    !(done && fault));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_fault_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    fault |=> !fault);
  assert_busy_after_take_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  assert_no_req_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);
  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  assert_offset_kept_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> (paddr[OFS_W-1:0] == seen_ofs));
endmodule

bind pgwalk_top pgwalk_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_vaddr     (req_vaddr),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_addr  (mem_req_addr),
  .mem_req_ready (mem_req_ready),
  .done          (done),
  .fault         (fault),
  .paddr         (paddr)
);

// File: tb/pgwalk_top_tb.sv
module pgwalk_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [27:0] req_l1_base = '0;
  logic        req_ready;
  logic        mem_req_valid;
  logic [27:0] mem_req_addr;
  logic        mem_req_ready = 1'b0;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done, fault;
  logic [27:0] paddr;

  always #5 clk = ~clk;

  pgwalk_top u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_l1_base(req_l1_base),
    .req_ready(req_ready),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .fault(fault), .paddr(paddr)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [27:0] m_addr [16];
  logic [31:0] m_data [16];
  int          m_cnt = 0;
  logic [27:0] rd_log [4];
  int          n_rd = 0;
  int          stall_cyc = 0;
  int          lat_cyc = 1;

  task automatic check(input bit ok, input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic mem_clear();
    m_cnt = 0;
  endtask

  task automatic mem_put(input logic [27:0] a, input logic [31:0] d);
    m_addr[m_cnt] = a;
    m_data[m_cnt] = d;
    m_cnt++;
  endtask

  function automatic logic [31:0] mem_get(input logic [27:0] a);
    for (int i = 0; i < m_cnt; i++)
      if (m_addr[i] == a) return m_data[i];
    return 32'h0;
  endfunction

  function automatic logic [27:0] l1_addr(input logic [27:0] base, input logic [31:0] va);
    return base + 28'(va[31:24]) * 28'd4;
  endfunction

  function automatic logic [27:0] l2_addr(input logic [31:0] e1, input logic [31:0] va);
    return {e1[27:13], 13'b0} + 28'(va[23:13]) * 28'd4;
  endfunction

  // memory responder
  initial begin
    int wait_n = 0;
    int pend = 0;
    logic [27:0] pend_a = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_req_ready = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem_get(pend_a);
        end
      end else if (mem_req_valid) begin
        if (wait_n < stall_cyc) begin
          wait_n++;
        end else begin
          mem_req_ready = 1'b1;
          pend_a = mem_req_addr;
          if (n_rd < 4) rd_log[n_rd] = mem_req_addr;
          n_rd++;
          pend = lat_cyc;
          wait_n = 0;
        end
      end
    end
  end

  // one walk; inject puts a foreign request on the input mid-walk
  task automatic walk(input logic [31:0] va, input logic [27:0] base, input bit inject,
                      output int n_done, output int n_fault, output logic [27:0] pa);
    int cyc = 0;
    bit seen = 0;
    n_done = 0; n_fault = 0; pa = '0; n_rd = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_l1_base = base;
    @(negedge clk);
    req_valid = 1'b0;
    while (cyc < 300) begin
      if (inject && cyc >= 1 && cyc <= 3 && !seen) begin
        check(req_ready == 1'b0, "R8 busy", 32'(req_ready), 0);
        req_valid = 1'b1; req_vaddr = ~va; req_l1_base = base + 28'h40;
      end else begin
        req_valid = 1'b0;
      end
      if (done)  begin n_done++;  pa = paddr; end
      if (fault) n_fault++;
      if (done || fault) seen = 1;
      else if (seen) break;
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    if (cyc >= 300) check(0, "R7 walk timeout", 32'(cyc), 300);
  endtask

  task automatic t_reset();
    check(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 1);
    check(mem_req_valid == 1'b0, "R1 mem_req_valid", 32'(mem_req_valid), 0);
    check(done == 1'b0 && fault == 1'b0, "R1 done/fault", {done, fault}, 0);
  endtask

  task automatic t_good(input logic [31:0] va, input logic [27:0] base,
                        input logic [31:0] e1, input logic [31:0] e2,
                        input bit inject, input string tag);
    int nd, nf;
    logic [27:0] pa;
    logic [27:0] exp_pa;
    mem_clear();
    mem_put(l1_addr(base, va), e1);
    mem_put(l2_addr(e1, va), e2);
    walk(va, base, inject, nd, nf, pa);
    exp_pa = {e2[27:13], va[12:0]};
    check(n_rd == 2, {tag, " R8 read count"}, 32'(n_rd), 2);
    check(rd_log[0] == l1_addr(base, va), {tag, " R2 l1 addr"}, 32'(rd_log[0]), 32'(l1_addr(base, va)));
    check(rd_log[1] == l2_addr(e1, va), {tag, " R3 l2 addr"}, 32'(rd_log[1]), 32'(l2_addr(e1, va)));
    check(nd == 1 && nf == 0, {tag, " R7 one done pulse"}, 32'(nd), 1);
    check(pa == exp_pa, {tag, " R4 paddr"}, 32'(pa), 32'(exp_pa));
  endtask

  task automatic t_known_index();
    int nd, nf;
    logic [27:0] pa;
    mem_clear();
    walk(32'h0400_0000, 28'h001_0000, 0, nd, nf, pa);
    check(rd_log[0] == 28'h001_0010, "R2 index 4 at 0x10010", 32'(rd_log[0]), 32'h10010);
  endtask

  task automatic t_l1_fault();
    int nd, nf;
    logic [27:0] pa;
    mem_clear();
    mem_put(l1_addr(28'h002_0000, 32'hAB00_1234), 32'h0FFF_E000);
    walk(32'hAB00_1234, 28'h002_0000, 0, nd, nf, pa);
    check(nf == 1 && nd == 0, "R5 fault pulse", {16'(nd), 16'(nf)}, 32'h1);
    check(n_rd == 1, "R5 single read", 32'(n_rd), 1);
  endtask

  task automatic t_l2_fault();
    int nd, nf;
    logic [27:0] pa;
    logic [31:0] e1 = 32'h0012_2001;
    mem_clear();
    mem_put(l1_addr(28'h003_0000, 32'h5555_5555), e1);
    mem_put(l2_addr(e1, 32'h5555_5555), 32'h0ABC_E000);
    walk(32'h5555_5555, 28'h003_0000, 0, nd, nf, pa);
    check(nf == 1 && nd == 0, "R6 fault pulse", {16'(nd), 16'(nf)}, 32'h1);
    check(n_rd == 2, "R6 two reads", 32'(n_rd), 2);
  endtask

  task automatic t_share();
    int nd, nf;
    logic [27:0] pa;
    logic [27:0] a0, a1, a2;
    mem_clear();
    walk(32'h1234_5678, 28'h001_0000, 0, nd, nf, pa); a0 = rd_log[0];
    walk(32'h123F_D000, 28'h001_0000, 0, nd, nf, pa); a1 = rd_log[0];
    walk(32'h0004_6678, 28'h001_0000, 0, nd, nf, pa); a2 = rd_log[0];
    check(a0 == a1, "R10 shared l1 entry", 32'(a1), 32'(a0));
    check(a0 != a2, "R10 distinct l1 entry", 32'(a2), 32'(a0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_known_index();
    stall_cyc = 0; lat_cyc = 1;
    t_good(32'h1234_5678, 28'h001_0000, 32'h0008_0001, 32'h0246_8001, 0, "basic");
    // entry junk bits above 27 and in 12:1 must not matter
    t_good(32'hFFFF_FFFF, 28'h00F_0000, 32'hF010_0FFF, 32'hFFFF_FFFF, 0, "allones");
    stall_cyc = 3; lat_cyc = 4;
    t_good(32'h8000_2001, 28'h0A0_0000, 32'h0333_2001, 32'h0777_0001, 0, "R9 stall");
    stall_cyc = 2; lat_cyc = 2;
    t_good(32'h0102_4ABC, 28'h004_0000, 32'h0044_4001, 32'h0155_5001, 1, "R8 inject");
    stall_cyc = 0; lat_cyc = 1;
    t_l1_fault();
    t_l2_fault();
    t_share();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule